// File: doc/BRIEF.md
# External Status Change Interrupt Unit

This block tracks six external and status conditions of one serial channel and turns a change on any of them into a single interrupt request for the host. The six sources are the clear-to-send, carrier-detect and sync modem pins, the receiver break/abort flag, the transmit underrun/end-of-message latch, and a one-cycle pulse from the baud counter when it reaches zero. The sync/hunt source is the sync pin in asynchronous mode and the receiver hunt flag in synchronous mode. A per-source enable mask decides which sources may raise the request.

Once an enabled change is seen, the request stays up and the status bits of the enabled sources hold the value they had when it was taken. This lasts until the host issues a reset-external-status command. Bits of disabled sources keep tracking their inputs. The block also assembles the eight-bit status word the host reads, with the transmit-buffer-empty and receive-character-available flags in it. It freezes that word for the whole read cycle so that a change in mid-read cannot tear the value.

Top module: `extstat_irq`

## Requirements
- R1: After hardware reset, `irq_ext` is 0. The enable mask resets to 1 for break/abort, underrun/EOM, CTS, sync/hunt and DCD, and to 0 for zero count.
- R2: A change in either direction on an enabled CTS, DCD, break/abort or underrun/EOM source sets `irq_ext`. The new level of that source then appears in the status word.
- R3: With `sync_mode`=0 the sync/hunt source is the `sync_pin` input and `rx_hunt` has no effect. With `sync_mode`=1 it is `rx_hunt` and `sync_pin` has no effect. Status bit D4 shows the selected one.
- R4: When the zero-count enable (mask bit 1) is 1, every cycle with `zero_cnt`=1 sets `irq_ext`. When that enable is 0, `zero_cnt` never sets it.
- R5: A change on a source whose enable is 0 does not set `irq_ext`. The status bit of that source follows its input.
- R6: `irq_ext` stays 1 until `rst_ext` is pulsed. While it is 1, the status bits of the enabled sources hold their captured values. After the pulse, the bits again follow the inputs.
- R7: Status word layout: D7 break/abort, D6 underrun/EOM, D5 CTS, D4 sync/hunt, D3 DCD, D2 `tx_empty`, D1 zero count, D0 `rx_avail`.
- R8: From the clock edge that first samples `rd_busy`=1, `stat_word` holds the value it had in the cycle before that edge. It holds until the edge that samples `rd_busy`=0, and then tracks live status again.
- R9: The three modem pins pass through a two-stage synchronizer. A pin change applied before clock edge 1 is seen as `irq_ext`=1 after edge 3, and not before.
- R10: A `chan_rst` pulse clears `irq_ext` and restores the reset enable mask of R1 (bits 2 and 0 of `mask_din` are not stored).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| chan_rst | input | 1 | Synchronous channel reset pulse |
| mask_wr | input | 1 | Write strobe for the enable mask |
| mask_din | input | 8 | Enable mask, bits placed as in the status word (bits 2 and 0 unused) |
| sync_mode | input | 1 | 0 asynchronous, 1 synchronous |
| cts_pin | input | 1 | Clear-to-send pin, asynchronous |
| dcd_pin | input | 1 | Carrier-detect pin, asynchronous |
| sync_pin | input | 1 | Sync pin, asynchronous |
| brk_abort | input | 1 | Receiver break/abort flag |
| tx_undr_eom | input | 1 | Transmit underrun/end-of-message latch |
| rx_hunt | input | 1 | Receiver hunt flag |
| zero_cnt | input | 1 | Baud counter reached-zero pulse |
| tx_empty | input | 1 | Transmit buffer empty |
| rx_avail | input | 1 | Receive character available |
| rd_busy | input | 1 | High while the host reads the status word |
| rst_ext | input | 1 | Reset-external-status command pulse |
| stat_word | output | 8 | Status word for the host |
| irq_ext | output | 1 | External/status interrupt request |

## Verification
The bench goes after the mixed reset defaults. A design that set the zero-count enable at reset would interrupt on every baud pulse, and one that cleared the others would stay silent on modem changes. It also targets falling as well as rising edges, the mode swap of the sync/hunt source, and the exact synchronizer latency. A one-direction detector, a swapped mode select or a missing stage each shows up at the interrupt pin at a known cycle. The freeze of enabled bits while the request is pending, the live tracking of disabled bits, and the read-cycle hold are checked against status words computed from the inputs. A design that released the read hold one cycle early, or froze every bit, would return the wrong word.

// File: rtl/extstat_pkg.sv
package extstat_pkg;
  localparam int WORD_W = 8;
  localparam int B_BRK  = 7;
  localparam int B_UND  = 6;
  localparam int B_CTS  = 5;
  localparam int B_SH   = 4;
  localparam int B_DCD  = 3;
  localparam int B_TXE  = 2;
  localparam int B_ZC   = 1;
  localparam int B_RXA  = 0;

  localparam logic [WORD_W-1:0] SRC_BITS   = 8'hFA;
  localparam logic [WORD_W-1:0] LEVEL_BITS = 8'hF8;
  localparam logic [WORD_W-1:0] PULSE_BITS = 8'h02;
  localparam logic [WORD_W-1:0] EN_RESET   = 8'hF8;

  // level sources fire on any toggle, pulse sources while high
  function automatic logic [WORD_W-1:0] source_events(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] prev
  );
    return ((cur ^ prev) & LEVEL_BITS) | (cur & PULSE_BITS);
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(
    input logic [WORD_W-1:0] held,
    input logic              txe,
    input logic              rxa
  );
    logic [WORD_W-1:0] w;
    w        = held & SRC_BITS;
    w[B_TXE] = txe;
    w[B_RXA] = rxa;
    return w;
  endfunction
endpackage

// File: rtl/extstat_sync.sv
module extstat_sync #(
  parameter int NPIN   = 3,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] raw,
  output logic [NPIN-1:0] synced
);
  logic [NPIN-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= raw;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= stg[k-1];
    end
  end

  assign synced = stg[STAGES-1];
endmodule

// File: rtl/extstat_track.sv
module extstat_track
  import extstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [WORD_W-1:0] src,
  input  logic [WORD_W-1:0] en,
  input  logic              ack,
  output logic [WORD_W-1:0] held,
  output logic              pending,
  output logic              hit
);
  logic [WORD_W-1:0] prev_q, held_q;
  logic              pend_q;
  logic [WORD_W-1:0] frz;

  assign hit = |(source_events(src, prev_q) & en);
  assign frz = {WORD_W{pend_q}} & en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      held_q <= '0;
      pend_q <= 1'b0;
    end else if (clr) begin
      prev_q <= src;
      held_q <= src;
      pend_q <= 1'b0;
    end else begin
      prev_q <= src;
      held_q <= (held_q & frz) | (src & ~frz);
      pend_q <= (pend_q & ~ack) | hit;
    end
  end

  assign held    = held_q;
  assign pending = pend_q;

  // R6
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !ack && !clr |=> pending);

  // R5
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pending && !hit && !clr |=> !pending);

  // R6
  frozen_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !clr |=> ((held & $past(en)) == ($past(held) & $past(en))));
endmodule

// File: rtl/extstat_rdhold.sv
module extstat_rdhold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd,
  input  logic [W-1:0] live,
  output logic [W-1:0] word
);
  logic         fz_q;
  logic [W-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fz_q   <= 1'b0;
      snap_q <= '0;
    end else begin
      fz_q <= rd;
      if (!fz_q) snap_q <= live;
    end
  end

  assign word = fz_q ? snap_q : live;

  // R8
  read_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fz_q && rd |=> $stable(word));
endmodule

// File: rtl/extstat_irq.sv
module extstat_irq
  import extstat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_rst,
  input  logic              mask_wr,
  input  logic [WORD_W-1:0] mask_din,
  input  logic              sync_mode,
  input  logic              cts_pin,
  input  logic              dcd_pin,
  input  logic              sync_pin,
  input  logic              brk_abort,
  input  logic              tx_undr_eom,
  input  logic              rx_hunt,
  input  logic              zero_cnt,
  input  logic              tx_empty,
  input  logic              rx_avail,
  input  logic              rd_busy,
  input  logic              rst_ext,
  output logic [WORD_W-1:0] stat_word,
  output logic              irq_ext
);
  localparam int NPIN = 3;

  logic [WORD_W-1:0] en_q;
  logic [NPIN-1:0]   pins_s;
  logic [WORD_W-1:0] src;
  logic [WORD_W-1:0] held;
  logic              pending;
  logic              ev_hit;
  logic [WORD_W-1:0] live_word;
  logic              sh_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= EN_RESET;
    else if (chan_rst) en_q <= EN_RESET;
    else if (mask_wr)  en_q <= mask_din & SRC_BITS;
  end

  extstat_sync #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    ({sync_pin, dcd_pin, cts_pin}),
    .synced (pins_s)
  );

  assign sh_src = sync_mode ? rx_hunt : pins_s[2];

  always_comb begin
    src        = '0;
    src[B_BRK] = brk_abort;
    src[B_UND] = tx_undr_eom;
    src[B_CTS] = pins_s[0];
    src[B_SH]  = sh_src;
    src[B_DCD] = pins_s[1];
    src[B_ZC]  = zero_cnt;
  end

  extstat_track u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (chan_rst),
    .src     (src),
    .en      (en_q),
    .ack     (rst_ext),
    .held    (held),
    .pending (pending),
    .hit     (ev_hit)
  );

  assign live_word = pack_word(held, tx_empty, rx_avail);

  extstat_rdhold #(.W(WORD_W)) u_rdhold (
    .clk   (clk),
    .rst_n (rst_n),
    .rd    (rd_busy),
    .live  (live_word),
    .word  (stat_word)
  );

  assign irq_ext = pending;

  // R10
  chan_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> !irq_ext);

  // R4
  zero_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_cnt && en_q[B_ZC] && !chan_rst |=> irq_ext);

  // R2
  event_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit && !chan_rst |=> irq_ext);
endmodule

// File: tb/test_extstat_irq.sv
module test_extstat_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chan_rst = 1'b0, mask_wr = 1'b0;
  logic [7:0] mask_din = 8'h00;
  logic       sync_mode = 1'b0;
  logic       cts_pin = 1'b0, dcd_pin = 1'b0, sync_pin = 1'b0;
  logic       brk_abort = 1'b0, tx_undr_eom = 1'b0, rx_hunt = 1'b0;
  logic       zero_cnt = 1'b0, tx_empty = 1'b1, rx_avail = 1'b0;
  logic       rd_busy = 1'b0, rst_ext = 1'b0;
  logic [7:0] stat_word;
  logic       irq_ext;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  extstat_irq i_extstat_irq (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .mask_wr(mask_wr),
    .mask_din(mask_din), .sync_mode(sync_mode), .cts_pin(cts_pin),
    .dcd_pin(dcd_pin), .sync_pin(sync_pin), .brk_abort(brk_abort),
    .tx_undr_eom(tx_undr_eom), .rx_hunt(rx_hunt), .zero_cnt(zero_cnt),
    .tx_empty(tx_empty), .rx_avail(rx_avail), .rd_busy(rd_busy),
    .rst_ext(rst_ext), .stat_word(stat_word), .irq_ext(irq_ext)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ack();
    rst_ext = 1'b1;
    tick(1);
    rst_ext = 1'b0;
  endtask

  task automatic wr_mask(input logic [7:0] v);
    mask_wr = 1'b1;
    mask_din = v;
    tick(1);
    mask_wr = 1'b0;
  endtask

  task automatic set_src(input int s, input logic v);
    case (s)
      0: cts_pin = v;
      1: dcd_pin = v;
      2: brk_abort = v;
      default: tx_undr_eom = v;
    endcase
  endtask

  initial begin
    #800000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state, word shows only tx_empty (D2)
    chk("R1 irq", {7'd0, irq_ext}, 8'h00);
    chk("R1 word", stat_word, 8'h04);

    // R2 / R9 both directions on four sources, default enables (R1)
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 2; d++) begin
        logic v;
        int   bitpos;
        v = (d == 0);
        bitpos = (s == 0) ? 5 : (s == 1) ? 3 : (s == 2) ? 7 : 6;
        set_src(s, v);
        if (s < 2) begin
          tick(2);
          chk("R9 early", {7'd0, irq_ext}, 8'h00);
          tick(1);
        end else begin
          tick(1);
        end
        chk("R2 irq", {7'd0, irq_ext}, 8'h01);
        chk("R2 bit", {7'd0, stat_word[bitpos]}, {7'd0, v});
        ack();
        chk("R6 cleared", {7'd0, irq_ext}, 8'h00);
      end
    end

    // R3 asynchronous mode: hunt ignored, pin counts
    rx_hunt = 1'b1;
    tick(3);
    chk("R3 hunt ignored", {7'd0, irq_ext}, 8'h00);
    chk("R3 d4 pin", {7'd0, stat_word[4]}, 8'h00);
    sync_pin = 1'b1;
    tick(2);
    chk("R9 sync early", {7'd0, irq_ext}, 8'h00);
    tick(1);
    chk("R3 pin irq", {7'd0, irq_ext}, 8'h01);
    chk("R3 d4 pin", {7'd0, stat_word[4]}, 8'h01);
    ack();
    // R3 synchronous mode: pin ignored, hunt counts
    sync_mode = 1'b1;
    tick(1);
    chk("R3 swap equal", {7'd0, irq_ext}, 8'h00);
    sync_pin = 1'b0;
    tick(3);
    chk("R3 pin ignored", {7'd0, irq_ext}, 8'h00);
    chk("R3 d4 hunt", {7'd0, stat_word[4]}, 8'h01);
    rx_hunt = 1'b0;
    tick(1);
    chk("R3 hunt irq", {7'd0, irq_ext}, 8'h01);
    chk("R3 d4 hunt", {7'd0, stat_word[4]}, 8'h00);
    ack();
    sync_mode = 1'b0;
    tick(1);

    // R4 zero count disabled by default; R5 its bit still follows
    zero_cnt = 1'b1;
    tick(1);
    chk("R4 default off", {7'd0, irq_ext}, 8'h00);
    chk("R5 d1 live", {7'd0, stat_word[1]}, 8'h01);
    zero_cnt = 1'b0;
    tick(1);
    chk("R5 d1 low", {7'd0, stat_word[1]}, 8'h00);
    wr_mask(8'h02);
    for (int k = 0; k < 3; k++) begin
      zero_cnt = 1'b1;
      tick(1);
      zero_cnt = 1'b0;
      chk("R4 pulse irq", {7'd0, irq_ext}, 8'h01);
      ack();
      chk("R4 ack", {7'd0, irq_ext}, 8'h00);
    end
    // R5 CTS disabled: no request, bit follows
    cts_pin = 1'b1;
    tick(3);
    chk("R5 cts off", {7'd0, irq_ext}, 8'h00);
    chk("R5 d5 live", {7'd0, stat_word[5]}, 8'h01);
    cts_pin = 1'b0;
    tick(3);

    // R6 hold and freeze
    wr_mask(8'hFF);
    brk_abort = 1'b1;
    tick(1);
    chk("R6 set", {7'd0, irq_ext}, 8'h01);
    brk_abort = 1'b0;
    tick(1);
    chk("R6 d7 frozen", {7'd0, stat_word[7]}, 8'h01);
    tick(5);
    chk("R6 held", {7'd0, irq_ext}, 8'h01);
    ack();
    chk("R6 ack", {7'd0, irq_ext}, 8'h00);
    tick(1);
    chk("R6 d7 released", {7'd0, stat_word[7]}, 8'h00);

    // R8 read freeze
    rd_busy = 1'b1;
    tick(1);
    chk("R8 start", stat_word, 8'h04);
    rx_avail = 1'b1;
    tx_empty = 1'b0;
    tick(2);
    chk("R8 held", stat_word, 8'h04);
    rd_busy = 1'b0;
    tick(1);
    chk("R8 released", stat_word, 8'h01);

    // R7 layout sweep with every source disabled
    wr_mask(8'h00);
    ack();
    for (int v = 0; v < 128; v++) begin
      logic [6:0] p;
      logic [7:0] e;
      p = v[6:0];
      brk_abort   = p[6];
      tx_undr_eom = p[5];
      cts_pin     = p[4];
      sync_pin    = p[3];
      dcd_pin     = p[2];
      tx_empty    = p[1];
      rx_avail    = p[0];
      tick(3);
      e = {p[6], p[5], p[4], p[3], p[2], p[1], 1'b0, p[0]};
      chk("R7 layout", stat_word, e);
      chk("R5 no irq", {7'd0, irq_ext}, 8'h00);
    end
    brk_abort = 1'b0; tx_undr_eom = 1'b0; cts_pin = 1'b0;
    sync_pin = 1'b0; dcd_pin = 1'b0; tx_empty = 1'b1; rx_avail = 1'b0;
    tick(3);

    // R10 channel reset restores enables
    chan_rst = 1'b1;
    tick(1);
    chan_rst = 1'b0;
    chk("R10 irq", {7'd0, irq_ext}, 8'h00);
    cts_pin = 1'b1;
    tick(3);
    chk("R10 cts on", {7'd0, irq_ext}, 8'h01);
    ack();
    zero_cnt = 1'b1;
    tick(1);
    zero_cnt = 1'b0;
    chk("R10 zero off", {7'd0, irq_ext}, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule